// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power Sequencer

This block sits on the controller side of an SDRAM interface. It owns the clock-enable line and the two low-power states that the line can put the memory into. The controller raises a low-power request. The sequencer samples a bank-active status at the moment of entry. With no bank open it takes the memory into power-down. With at least one bank open it takes it into clock-suspend. While the clock-enable line is low, or while the memory is coming back out, the sequencer withholds a command-permission signal. That signal gates the controller's command encoder.

Power-down is left through one forced no-op cycle with clock-enable high. A settling window of a parameterised number of cycles follows, still forcing no-ops. Clock-suspend is left through a single extra cycle, because the memory itself takes one clock to resume. Power-down performs no refresh, so a timer ends any power-down stay once a parameterised cycle limit is reached. After such a forced exit, a request that is still held cannot start a new entry until it has dropped. This lets the refresh logic reach the memory. A one-cycle ready pulse marks the first cycle in which commands are allowed again.

Top module: `sdram_cke_seq`

## Requirements
- R1: During reset and afterwards with no request, cke=1, cmd_allow=1, and nop_force, pd_active, susp_active and ready are all 0.
- R2: With lp_req=1, bank_active=0 and no hold-off pending, the next cycle shows cke=0, pd_active=1 and cmd_allow=0.
- R3: With lp_req=1 and bank_active=1, the next cycle shows cke=0, susp_active=1 and cmd_allow=0.
- R4: A power-down stay ends on the cycle after lp_req is seen low. The exit then runs as follows:
  - one cycle with cke=1, nop_force=1 and cmd_allow=0;
  - EXIT_CYC further cycles with the same values;
  - after that, cmd_allow=1.
- R5: A clock-suspend stay ends on the cycle after lp_req is seen low. One cycle follows with cke=1, susp_active=1 and cmd_allow=0. On the cycle after that, cmd_allow=1 and susp_active=0.
- R6: pd_active stays high for at most PD_MAX_CYC consecutive cycles. When the limit is reached with lp_req still high, the exit sequence of R4 runs.
- R7: ready is high for exactly one cycle: the first cycle with cmd_allow=1 after any low-power exit.
- R8: After a forced power-down exit, a held lp_req starts no new entry. It must first be seen low for at least one cycle.
- R9: bank_active is sampled only at entry. Changing it during a low-power stay does not change the mode.
- R10: cmd_allow is 0 whenever cke is 0 or nop_force is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Request to enter (held high) or leave (low) a low-power state |
| bank_active | input | 1 | At least one bank is open; picks clock-suspend over power-down |
| cke | output | 1 | Clock-enable line to the memory |
| cmd_allow | output | 1 | Command encoder may issue real commands |
| nop_force | output | 1 | Encoder must issue no-ops (power-down exit window) |
| pd_active | output | 1 | Memory is in power-down |
| susp_active | output | 1 | Memory is in clock-suspend or its exit cycle |
| ready | output | 1 | One-cycle pulse when commands are allowed again |

## Verification
The hardest situation to reach is a forced power-down exit while the request is still held, followed by the hold-off that must block re-entry. The stimulus holds lp_req high for well over PD_MAX_CYC cycles and keeps it high through the exit window and several normal cycles. It then drops the request for exactly one cycle and raises it again, which must re-enter at once. A second awkward case is toggling bank_active in the middle of a stay. The bench toggles it both ways during a suspend and during a power-down.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PD        = 3'd1,
        ST_PD_NOP    = 3'd2,
        ST_PD_WAIT   = 3'd3,
        ST_SUSP      = 3'd4,
        ST_SUSP_EXIT = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic cke;
        logic cmd_ok;
        logic nop;
        logic pd;
        logic susp;
    } seq_out_t;

    function automatic seq_out_t decode_state(input seq_state_e s);
        seq_out_t o;
        o.cke    = !(s == ST_PD || s == ST_SUSP);
        o.cmd_ok = (s == ST_RUN);
        o.nop    = (s == ST_PD_NOP || s == ST_PD_WAIT);
        o.pd     = (s == ST_PD);
        o.susp   = (s == ST_SUSP || s == ST_SUSP_EXIT);
        return o;
    endfunction

endpackage

// File: rtl/cke_cycle_timer.sv
module cke_cycle_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != W'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/cke_seq_ctrl.sv
module cke_seq_ctrl
    import cke_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_req,
    input  logic       bank_active,
    input  logic       pd_expire,
    input  logic       exit_done,
    output seq_state_e state,
    output logic       ready
);
    seq_state_e nxt;
    logic       hold;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:       if (lp_req && !hold) nxt = bank_active ? ST_SUSP : ST_PD;
            ST_PD:        if (!lp_req || pd_expire) nxt = ST_PD_NOP;
            ST_PD_NOP:    nxt = ST_PD_WAIT;
            ST_PD_WAIT:   if (exit_done) nxt = ST_RUN;
            ST_SUSP:      if (!lp_req) nxt = ST_SUSP_EXIT;
            ST_SUSP_EXIT: nxt = ST_RUN;
            default:      nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            hold  <= 1'b0;
            ready <= 1'b0;
        end else begin
            state <= nxt;
            ready <= (state == ST_PD_WAIT && exit_done) || (state == ST_SUSP_EXIT);
            if (state == ST_PD && lp_req && pd_expire) hold <= 1'b1;
            else if (!lp_req)                           hold <= 1'b0;
        end
    end

    // R8: a held request never re-enters straight after a forced exit
    a_r8_holdoff: assert property (@(posedge clk) disable iff (rst)
        (hold && state == ST_RUN) |=> (state == ST_RUN));
endmodule

// File: rtl/sdram_cke_seq.sv
module sdram_cke_seq
    import cke_seq_pkg::*;
#(
    parameter int PD_MAX_CYC = 64,
    parameter int EXIT_CYC   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_req,
    input  logic bank_active,
    output logic cke,
    output logic cmd_allow,
    output logic nop_force,
    output logic pd_active,
    output logic susp_active,
    output logic ready
);
    localparam int RUN_W = $clog2(PD_MAX_CYC + 2);

    seq_state_e state;
    seq_out_t   outs;
    logic       pd_expire;
    logic       exit_done;

    cke_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lp_req     (lp_req),
        .bank_active(bank_active),
        .pd_expire  (pd_expire),
        .exit_done  (exit_done),
        .state      (state),
        .ready      (ready)
    );

    cke_cycle_timer #(.LIMIT(PD_MAX_CYC)) u_pd_limit (
        .clk (clk),
        .rst (rst),
        .run (state == ST_PD),
        .last(pd_expire)
    );

    cke_cycle_timer #(.LIMIT(EXIT_CYC)) u_exit_wait (
        .clk (clk),
        .rst (rst),
        .run (state == ST_PD_WAIT),
        .last(exit_done)
    );

    assign outs        = decode_state(state);
    assign cke         = outs.cke;
    assign cmd_allow   = outs.cmd_ok;
    assign nop_force   = outs.nop;
    assign pd_active   = outs.pd;
    assign susp_active = outs.susp;

    // checker: consecutive power-down cycles already spent
    logic [RUN_W-1:0] pd_run;
    always_ff @(posedge clk) begin
        if (rst)            pd_run <= '0;
        else if (pd_active) pd_run <= pd_run + 1'b1;
        else                pd_run <= '0;
    end

    a_r10_no_cmd_low: assert property (@(posedge clk) disable iff (rst)
        (!cke || nop_force) |-> !cmd_allow);
    a_r4_nop_first: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_active) |-> (cke && nop_force));
    a_r5_susp_resume: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_active) |-> (cmd_allow && ready));
    a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    a_r6_pd_bound: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> (pd_run < RUN_W'(PD_MAX_CYC)));
    a_r3_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pd_active && susp_active));
endmodule

// File: tb/sdram_cke_seq_test.sv
module sdram_cke_seq_test;
    localparam int PDMAX = 12;
    localparam int EXW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_req = 1'b0;
    logic bank_active = 1'b0;
    logic cke, cmd_allow, nop_force, pd_active, susp_active, ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_cke_seq #(.PD_MAX_CYC(PDMAX), .EXIT_CYC(EXW)) uut (
        .clk(clk), .rst(rst), .lp_req(lp_req), .bank_active(bank_active),
        .cke(cke), .cmd_allow(cmd_allow), .nop_force(nop_force),
        .pd_active(pd_active), .susp_active(susp_active), .ready(ready)
    );

    // behavioural reference: phase 0 normal, 1 pd, 2 pd nop, 3 pd settle, 4 suspend, 5 suspend exit
    int ph = 0, pdc = 0, wc = 0;
    bit hold_m = 0, rdy_m = 0;
    always @(posedge clk) begin
        if (rst) begin
            ph = 0; pdc = 0; wc = 0; hold_m = 0; rdy_m = 0;
        end else begin
            rdy_m = 0;
            case (ph)
                0: if (lp_req && !hold_m) begin ph = bank_active ? 4 : 1; pdc = 1; end
                1: if (!lp_req) ph = 2;
                   else if (pdc == PDMAX) begin ph = 2; hold_m = 1; end
                   else pdc++;
                2: begin ph = 3; wc = 1; end
                3: if (wc == EXW) begin ph = 0; rdy_m = 1; end else wc++;
                4: if (!lp_req) ph = 5;
                5: begin ph = 0; rdy_m = 1; end
                default: ph = 0;
            endcase
            if (!lp_req) hold_m = 0;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tag;
        case (ph)
            1: tag = "R2";
            2, 3: tag = "R4";
            4: tag = "R3";
            5: tag = "R5";
            default: tag = rdy_m ? "R7" : (hold_m ? "R8" : "R1");
        endcase
        chk(tag, cke, !(ph == 1 || ph == 4), "cke");
        chk(tag, cmd_allow, ph == 0, "cmd_allow");
        chk(tag, nop_force, ph == 2 || ph == 3, "nop_force");
        chk(tag, pd_active, ph == 1, "pd_active");
        chk(tag, susp_active, ph == 4 || ph == 5, "susp_active");
        chk(tag, ready, rdy_m, "ready");
        // R10: no command permission with cke low or no-ops forced
        if (!cke || nop_force) chk("R10", cmd_allow, 1'b0, "cmd_allow gated");
    endtask

    int pd_len = 0, pd_max_seen = 0;
    always @(negedge clk) begin
        if (!rst) begin
            compare_all();
            if (pd_active) pd_len++; else pd_len = 0;
            if (pd_len > pd_max_seen) pd_max_seen = pd_len;
        end
    end

    // inputs change just after the negedge compare
    task automatic step(input logic lp, input logic ba, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
            lp_req = lp; bank_active = ba;
        end
    endtask

    initial begin
        @(negedge clk); #0.5;
        // R1: reset values
        chk("R1", cke, 1'b1, "reset cke");
        chk("R1", cmd_allow, 1'b1, "reset cmd_allow");
        chk("R1", ready, 1'b0, "reset ready");
        step(0, 0, 2);
        rst = 1'b0;
        step(0, 0, 3);
        // normal power-down and exit
        step(1, 0, 6);
        step(0, 0, 8);
        // suspend, bank status dropping mid-stay (R9)
        step(1, 1, 3);
        step(1, 0, 3);
        chk("R9", susp_active, 1'b1, "mode kept");
        step(0, 0, 5);
        // power-down with bank status rising mid-stay (R9)
        step(1, 0, 3);
        step(1, 1, 2);
        chk("R9", pd_active, 1'b1, "mode kept");
        step(0, 1, 8);
        // forced exit and hold-off (R6, R8)
        pd_max_seen = 0;
        step(1, 0, PDMAX + EXW + 10);
        chk("R8", cmd_allow, 1'b1, "no re-entry while held");
        chk("R6", pd_max_seen == PDMAX, 1'b1, "pd length at limit");
        step(0, 0, 1);
        step(1, 0, 4);
        chk("R8", pd_active, 1'b1, "re-entry after drop");
        step(0, 0, 8);
        // request raised straight through the ready cycle
        step(1, 1, 2);
        step(0, 1, 1);
        step(1, 0, 4);
        step(0, 0, 8);
        // short one-cycle power-down
        step(1, 0, 1);
        step(0, 0, 8);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule